// File: doc/BRIEF.md
# Regulator Enable Control Register

This block is the 32-bit control word for a group of eight traffic regulators on one interconnect port. The group has rate, latency-feedback and outstanding-transaction regulators, each for the read-address channel, the write-address channel, or both channels together. Software writes the word over a single-cycle write strobe and reads it back. The block turns the stored enable bits into a per-regulator activate level and a one-cycle reset pulse for each regulator. It also exports the two latency measurement mode selects.

A regulator is activated only when two conditions hold: its enable bit is set, and the value programmed into it elsewhere is non-zero. A status input reports that second condition for each regulator. This lets integration tests set enables without changing traffic. A regulator is reset each time its enable changes from 0 to 1, so software can clear and then set an enable to soft-reset that regulator. Each of the three feature groups can be left out at build time. A group that is left out reads as zero and ignores writes.

Top module: `regulator_enable_reg`

## Requirements
- R1: After reset the read word, every activate output, every reset pulse and both mode outputs are 0.
- R2: Activate bit i is 1 exactly when enable bit i is 1 and value_nonzero_i[i] is 1. It follows value_nonzero_i in the same cycle, with no register in between.
- R3: When an enable bit changes from 0 to 1 through a write, the matching reset pulse bit is 1 for exactly the one cycle that follows the write edge.
- R4: A write that leaves an already-set enable bit at 1 produces no reset pulse for that bit.
- R5: Bit 16 is the write-address latency mode and bit 20 is the read-address latency mode. The value 0 selects transaction latency and 1 selects address latency. The mode outputs follow these stored bits, and changing a mode while its enable stays 1 produces no reset pulse.
- R6: Enable bit positions and pulse/activate indices are: 0 write rate, 1 read rate, 2 combined rate, 3 write latency, 4 read latency, 5 write outstanding, 6 read outstanding, 7 combined outstanding.
- R7: Bits 31:21, 19:17 and 15:8 always read as 0, and writing 1 to them changes nothing.
- R8: Each excluded feature group reads as 0 and cannot be written: rate (bits 2:0), latency (bits 4:3 and mode bits 16 and 20), outstanding (bits 7:5).
- R9: Clearing an enable and then setting it again produces a new reset pulse.
- R10: In a cycle without a write strobe the stored word does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Single-cycle write strobe |
| wr_data_i | input | 32 | Write data word |
| rd_data_o | output | 32 | Stored word, with reserved and excluded bits read as 0 |
| value_nonzero_i | input | 8 | Per-regulator flag: the programmed value is non-zero |
| active_o | output | 8 | Per-regulator activate level |
| reg_rst_pulse_o | output | 8 | Per-regulator one-cycle reset pulse |
| aw_lat_addr_mode_o | output | 1 | Write-address latency mode (1 = address latency) |
| ar_lat_addr_mode_o | output | 1 | Read-address latency mode (1 = address latency) |

## Verification
A write presented before clock edge N is stored at edge N. The read word, the mode outputs and the reset pulse all show the result in the cycle after edge N. The pulse must be gone again one cycle later. Activate outputs are combinational in value_nonzero_i, so they are due in the same cycle that the status input changes. The bench drives inputs on the falling edge and samples every output on the next falling edge, and for pulse lifetime it samples once more a full cycle later.

// File: rtl/regen_pkg.sv
package regen_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned NUM_REG  = 8;
  localparam int unsigned BIT_AW_MODE = 16;
  localparam int unsigned BIT_AR_MODE = 20;

  // Which bits of the word hold state, given the build-time feature set.
  function automatic logic [WORD_W-1:0] regen_write_mask(input bit has_rate,
                                                          input bit has_lat,
                                                          input bit has_ot);
    logic [WORD_W-1:0] m;
    m = '0;
    if (has_rate) m[2:0] = 3'b111;
    if (has_lat) begin
      m[4:3]         = 2'b11;
      m[BIT_AW_MODE] = 1'b1;
      m[BIT_AR_MODE] = 1'b1;
    end
    if (has_ot) m[7:5] = 3'b111;
    return m;
  endfunction

  function automatic logic [NUM_REG-1:0] regen_enables(input logic [WORD_W-1:0] w);
    return w[NUM_REG-1:0];
  endfunction

  function automatic logic regen_rise(input logic prev, input logic next);
    return next & ~prev;
  endfunction
endpackage

// File: rtl/regen_store.sv
module regen_store
  import regen_pkg::*;
#(
  parameter logic [WORD_W-1:0] MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] q_o,
  output logic [WORD_W-1:0] q_next_o
);
  logic [WORD_W-1:0] q;

  always_comb begin
    q_next_o = q;
    if (wr_en_i) q_next_o = wr_data_i & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next_o;
  end

  assign q_o = q;
endmodule

// File: rtl/regen_pulse.sv
module regen_pulse
  import regen_pkg::*;
#(
  parameter int unsigned N = NUM_REG
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] en_cur_i,
  input  logic [N-1:0] en_next_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] pulse_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign rise_o[i] = regen_rise(en_cur_i[i], en_next_i[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_o[i] <= 1'b0;
      else        pulse_o[i] <= rise_o[i];
    end
  end
endmodule

// File: rtl/regen_gate.sv
module regen_gate #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] nonzero_i,
  output logic [N-1:0] active_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign active_o[i] = en_i[i] & nonzero_i[i];
  end
endmodule

// File: rtl/regulator_enable_reg.sv
module regulator_enable_reg
  import regen_pkg::*;
#(
  parameter bit HAS_RATE = 1'b1,
  parameter bit HAS_LAT  = 1'b1,
  parameter bit HAS_OT   = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  input  logic [7:0]  value_nonzero_i,
  output logic [7:0]  active_o,
  output logic [7:0]  reg_rst_pulse_o,
  output logic        aw_lat_addr_mode_o,
  output logic        ar_lat_addr_mode_o
);
  localparam logic [WORD_W-1:0] MASK = regen_write_mask(HAS_RATE, HAS_LAT, HAS_OT);

  logic [WORD_W-1:0]  word_q;
  logic [WORD_W-1:0]  word_next;
  logic [NUM_REG-1:0] en_rise;

  regen_store #(.MASK(MASK)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .q_o(word_q), .q_next_o(word_next)
  );

  regen_pulse #(.N(NUM_REG)) u_pulse (
    .clk(clk), .rst_n(rst_n),
    .en_cur_i(regen_enables(word_q)), .en_next_i(regen_enables(word_next)),
    .rise_o(en_rise), .pulse_o(reg_rst_pulse_o)
  );

  regen_gate #(.N(NUM_REG)) u_gate (
    .en_i(regen_enables(word_q)), .nonzero_i(value_nonzero_i), .active_o(active_o)
  );

  assign rd_data_o          = word_q;
  assign aw_lat_addr_mode_o = word_q[BIT_AW_MODE];
  assign ar_lat_addr_mode_o = word_q[BIT_AR_MODE];
endmodule

// File: rtl/regulator_enable_reg_chk.sv
module regulator_enable_reg_chk
  import regen_pkg::*;
#(
  parameter logic [31:0] MASK = '1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en_i,
  input logic [31:0] rd_data_o,
  input logic [7:0]  value_nonzero_i,
  input logic [7:0]  active_o,
  input logic [7:0]  reg_rst_pulse_o,
  input logic [7:0]  en_rise
);
  // R2: no regulator is active without a non-zero value behind it
  p_active_needs_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o & ~value_nonzero_i) == '0);
  // R2: no regulator is active while its enable bit reads 0
  p_active_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o & ~rd_data_o[7:0]) == '0);
  // R3: each pulse shows an enable that reads 1 now and read 0 one cycle earlier
  p_pulse_is_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rst_pulse_o & ~(rd_data_o[7:0] & ~$past(rd_data_o[7:0]))) == '0);
  // R3: a pulse never lasts two cycles
  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rst_pulse_o & $past(reg_rst_pulse_o)) == '0);
  // R3: each detected rise is followed by a pulse on the next edge
  p_rise_then_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise != '0) |=> ((reg_rst_pulse_o & $past(en_rise)) == $past(en_rise)));
  // R7 / R8: bits that hold no state read as zero
  p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o & ~MASK) == '0);
  // R10: the word holds when no write strobe is given
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(rd_data_o));
endmodule

bind regulator_enable_reg regulator_enable_reg_chk #(.MASK(MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .rd_data_o(rd_data_o),
  .value_nonzero_i(value_nonzero_i), .active_o(active_o),
  .reg_rst_pulse_o(reg_rst_pulse_o), .en_rise(en_rise)
);

// File: tb/regulator_enable_reg_tb.sv
module regulator_enable_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [7:0]  nz = '0;
  logic [31:0] rd, rd_l;
  logic [7:0]  act, act_l, pls, pls_l;
  logic        awm, arm, awm_l, arm_l;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  regulator_enable_reg u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd),
    .value_nonzero_i(nz), .active_o(act), .reg_rst_pulse_o(pls),
    .aw_lat_addr_mode_o(awm), .ar_lat_addr_mode_o(arm)
  );

  regulator_enable_reg #(.HAS_RATE(1'b0), .HAS_LAT(1'b1), .HAS_OT(1'b0)) u_dut_lite (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_l),
    .value_nonzero_i(nz), .active_o(act_l), .reg_rst_pulse_o(pls_l),
    .aw_lat_addr_mode_o(awm_l), .ar_lat_addr_mode_o(arm_l)
  );

  // Each entry: write word, value-nonzero flags, expected read, expected pulse, expected activate.
  typedef struct packed {
    logic [31:0] wd;
    logic [7:0]  nzv;
    logic [31:0] erd;
    logic [7:0]  epls;
    logic [7:0]  eact;
  } vec_t;
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0001, 8'hFF, 32'h0000_0001, 8'h01, 8'h01}, // R3 R6
    '{32'h0000_0003, 8'hFF, 32'h0000_0003, 8'h02, 8'h03}, // R4
    '{32'h0011_0003, 8'h01, 32'h0011_0003, 8'h00, 8'h01}, // R2 R5
    '{32'hFFFF_FFFF, 8'hFF, 32'h0011_00FF, 8'hFC, 8'hFF}, // R7
    '{32'h0000_00FE, 8'h55, 32'h0000_00FE, 8'h00, 8'h54}, // R2
    '{32'h0000_00FF, 8'hAA, 32'h0000_00FF, 8'h01, 8'hAA}, // R9
    '{32'h0000_0000, 8'hFF, 32'h0000_0000, 8'h00, 8'h00}, // R2
    '{32'h0000_0018, 8'hFF, 32'h0000_0018, 8'h18, 8'h18}  // R6
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Write on the falling edge, stored at the next rising edge, sampled at the following falling edge.
  task automatic do_write(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    nz = 8'hFF;
    repeat (3) @(negedge clk);
    check("R1 read", rd, 32'h0);
    check("R1 active", {24'h0, act}, 32'h0);
    check("R1 pulse", {24'h0, pls}, 32'h0);
    check("R1 modes", {30'h0, awm, arm}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      nz = VECS[i].nzv;
      do_write(VECS[i].wd);
      check($sformatf("R3 table %0d pulse", i), {24'h0, pls}, {24'h0, VECS[i].epls});
      check($sformatf("R7 table %0d read", i), rd, VECS[i].erd);
      check($sformatf("R2 table %0d active", i), {24'h0, act}, {24'h0, VECS[i].eact});
      @(negedge clk);
      check($sformatf("R3 table %0d pulse gone", i), {24'h0, pls}, 32'h0);
    end

    // R5: mode change with enable held at 1; the mode outputs follow, no pulse
    do_write(32'h0011_0018);
    check("R5 no pulse on mode change", {24'h0, pls}, 32'h0);
    check("R5 modes set", {30'h0, awm, arm}, 32'h3);
    do_write(32'h0001_0018);
    check("R5 AW mode only", {30'h0, awm, arm}, 32'h2);

    // R10: no strobe, data on the bus ignored
    wr_data = 32'hFFFF_FFFF;
    @(negedge clk); @(negedge clk);
    check("R10 hold", rd, 32'h0001_0018);
    check("R10 no pulse", {24'h0, pls}, 32'h0);

    // R2: activate follows value_nonzero in the same cycle
    nz = 8'h08;
    #1;
    check("R2 combinational", {24'h0, act}, 32'h08);
    nz = 8'hFF;

    // R8: the lite build keeps only the latency group
    do_write(32'h0);
    do_write(32'hFFFF_FFFF);
    check("R8 lite read", rd_l, 32'h0011_0018);
    check("R8 lite pulse", {24'h0, pls_l}, 32'h18);
    check("R8 lite active", {24'h0, act_l}, 32'h18);
    check("R8 full read", rd, 32'h0011_00FF);

    // R1: reset again mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset again", rd, 32'h0);
    check("R1 reset active", {24'h0, act}, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule